// File: doc/BRIEF.md
# Flash Write-Strobe Qualifier

This block sits between the synchronised control strobes of a flash memory's command port and its command decoder. It watches the active-low chip-enable, output-enable and write-enable levels together with a digital supply-good flag. It emits a one-cycle write-latch pulse only for a write that passes every protection rule. Short noise pulses on the strobes are filtered out by requiring a write condition to persist for a programmable number of sampled clock edges. Any combination of strobe levels that is not a legal write blocks the write. All accesses are refused while the supply is reported low. After the supply comes up, or comes back, commands are held off for a programmable number of cycles.

The decoder sees a single pulse in the cycle after write-enable is sampled returning high, which marks the command capture point. A registered read-permit level is provided as well, so that the array read path can be silenced during a low-supply condition. All timing is counted in clock cycles of the sampling clock.

Top module: `flash_wr_qualifier`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `wr_latch_o` and `rd_allow_o` are 0.
- R2: No `wr_latch_o` pulse occurs unless `supply_ok_i` has been sampled high on at least `PWRUP_CYCLES` consecutive edges before the first edge of the write condition. Writes started during the hold-off are discarded.
- R3: Sampling `supply_ok_i` low restarts the hold-off count from zero.
- R4: The write condition is `ce_n_i`=0, `we_n_i`=0 and `oe_n_i`=1 together. Any other level combination counts as no write, and `oe_n_i`=0 alone blocks a write.
- R5: A write is accepted only after the write condition has been sampled on `GLITCH_LEN` consecutive edges (default 4, bench 3). Shorter pulses produce no `wr_latch_o`.
- R6: After an accepted write, the first edge that samples `we_n_i`=1 while `oe_n_i`=1 and `supply_ok_i`=1 makes `wr_latch_o` high for exactly the following cycle.
- R7: If `ce_n_i` rises or `oe_n_i` falls before `we_n_i` rises, the write is dropped with no pulse. If `oe_n_i` is sampled 0 on the edge where `we_n_i` rises, no pulse is produced either.
- R8: While `supply_ok_i` is sampled low, no `wr_latch_o` pulse and no `rd_allow_o` follow. A supply drop during a write aborts it.
- R9: `rd_allow_o` is 1 in the cycle after an edge that samples `supply_ok_i`=1, `ce_n_i`=0 and `oe_n_i`=0, and 0 otherwise.
- R10: `wr_latch_o` is never high on two consecutive cycles. A write-enable low phase of any length gives at most one pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n_i | input | 1 | Synchronised chip-enable, active low |
| oe_n_i | input | 1 | Synchronised output-enable, active low |
| we_n_i | input | 1 | Synchronised write-enable, active low |
| supply_ok_i | input | 1 | High when the supply is above the lockout threshold |
| wr_latch_o | output | 1 | One-cycle command capture pulse |
| rd_allow_o | output | 1 | Registered read permission |

## Verification
Two protections can land on the very edge where an accepted write would be latched. One is the supply dropping as write-enable returns high. The other is output-enable falling on that same edge. The bench drives both coincidences on purpose after a filtered, fully armed write, and requires that no pulse appears in the following cycle. A behavioural model, run on every clock, confirms that the filter and hold-off counts start again cleanly afterwards.

// File: rtl/fwq_pkg.sv
// Package: shared strobe type and helper for the flash write qualifier.
// Assumes strobes are already synchronous to the block clock.
package fwq_pkg;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } fwq_strobe_t;

    // True when the strobe levels describe a legal write.
    function automatic logic fwq_write_level(input fwq_strobe_t s);
        return (!s.ce_n) && (!s.we_n) && s.oe_n;
    endfunction

    // True when the strobe levels describe a read.
    function automatic logic fwq_read_level(input fwq_strobe_t s);
        return (!s.ce_n) && (!s.oe_n);
    endfunction

endpackage

// File: rtl/fwq_pwrup_timer.sv
// Module: fwq_pwrup_timer
// Counts consecutive cycles of good supply and raises armed_o once
// PWRUP_CYCLES have elapsed. Any low supply sample restarts the count.
// Assumes supply_ok_i is synchronous; PWRUP_CYCLES >= 1.
module fwq_pwrup_timer #(
    parameter int PWRUP_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    output logic armed_o
);
    localparam int CW = $clog2(PWRUP_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PWRUP_CYCLES);

    logic [CW-1:0] cnt_q;

    // Saturating hold-off counter, cleared by reset or supply loss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!supply_ok_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Armed once the counter has reached its limit.
    always_comb begin
        armed_o = (cnt_q == LIMIT);
    end

endmodule

// File: rtl/fwq_glitch_filter.sv
// Module: fwq_glitch_filter
// Raises active_o after qual_i has been sampled high on GLITCH_LEN
// consecutive edges; drops it at once when qual_i is sampled low.
// Assumes GLITCH_LEN >= 1.
module fwq_glitch_filter #(
    parameter int GLITCH_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual_i,
    output logic active_o
);
    localparam int CW = (GLITCH_LEN > 1) ? $clog2(GLITCH_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(GLITCH_LEN - 1);

    logic [CW-1:0] run_q;
    logic          active_q;

    // Consecutive-sample run counter and accepted flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= '0;
            active_q <= 1'b0;
        end else if (!qual_i) begin
            run_q    <= '0;
            active_q <= 1'b0;
        end else if (!active_q) begin
            if (run_q == LAST) begin
                active_q <= 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // Expose the accepted flag.
    always_comb begin
        active_o = active_q;
    end

endmodule

// File: rtl/fwq_strobe_gate.sv
// Module: fwq_strobe_gate
// Combines logical-level inhibit, supply lockout and hold-off into the
// qualify level for the filter, and registers the latch pulse and the
// read permit. Assumes active_i comes from a filter fed by qual_o.
module fwq_strobe_gate
    import fwq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  fwq_strobe_t strb_i,
    input  logic        supply_ok_i,
    input  logic        armed_i,
    input  logic        active_i,
    output logic        qual_o,
    output logic        wr_latch_o,
    output logic        rd_allow_o
);
    logic latch_d;
    logic read_d;
    logic latch_q;
    logic read_q;

    // Qualify level and next-state of both outputs.
    always_comb begin
        qual_o  = supply_ok_i && armed_i && fwq_write_level(strb_i);
        latch_d = active_i && strb_i.we_n && strb_i.oe_n && supply_ok_i;
        read_d  = supply_ok_i && fwq_read_level(strb_i);
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
            read_q  <= 1'b0;
        end else begin
            latch_q <= latch_d;
            read_q  <= read_d;
        end
    end

    // Drive ports from the registers.
    always_comb begin
        wr_latch_o = latch_q;
        rd_allow_o = read_q;
    end

endmodule

// File: rtl/flash_wr_qualifier.sv
// Module: flash_wr_qualifier (top)
// Qualifies flash write strobes: glitch filter, level inhibit, supply
// lockout and power-up hold-off, giving a one-cycle command latch pulse.
// Assumes all inputs are already synchronous to clk.
module flash_wr_qualifier
    import fwq_pkg::*;
#(
    parameter int PWRUP_CYCLES = 250000,
    parameter int GLITCH_LEN   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_i,
    input  logic oe_n_i,
    input  logic we_n_i,
    input  logic supply_ok_i,
    output logic wr_latch_o,
    output logic rd_allow_o
);
    fwq_strobe_t strb;
    logic        armed;
    logic        qual;
    logic        active;

    // Bundle the strobes.
    always_comb begin
        strb.ce_n = ce_n_i;
        strb.oe_n = oe_n_i;
        strb.we_n = we_n_i;
    end

    fwq_pwrup_timer #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok_i (supply_ok_i),
        .armed_o     (armed)
    );

    fwq_glitch_filter #(.GLITCH_LEN(GLITCH_LEN)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual_i   (qual),
        .active_o (active)
    );

    fwq_strobe_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .strb_i      (strb),
        .supply_ok_i (supply_ok_i),
        .armed_i     (armed),
        .active_i    (active),
        .qual_o      (qual),
        .wr_latch_o  (wr_latch_o),
        .rd_allow_o  (rd_allow_o)
    );

endmodule

// File: rtl/flash_wr_qualifier_chk.sv
// Module: flash_wr_qualifier_chk
// Port-level assertions for flash_wr_qualifier, bound to every instance.
module flash_wr_qualifier_chk #(
    parameter int PWRUP_CYCLES = 250000,
    parameter int GLITCH_LEN   = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n_i,
    input logic oe_n_i,
    input logic we_n_i,
    input logic supply_ok_i,
    input logic wr_latch_o,
    input logic rd_allow_o
);
    localparam int SUP_CAP = PWRUP_CYCLES + GLITCH_LEN + 2;
    localparam int RUN_CAP = GLITCH_LEN + 1;

    int sup_run;
    int wr_run;
    int wr_run_prev;

    // Independent counts of good-supply and write-level runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sup_run     <= 0;
            wr_run      <= 0;
            wr_run_prev <= 0;
        end else begin
            sup_run     <= !supply_ok_i ? 0 : (sup_run < SUP_CAP ? sup_run + 1 : sup_run);
            wr_run      <= (supply_ok_i && !ce_n_i && !we_n_i && oe_n_i)
                           ? (wr_run < RUN_CAP ? wr_run + 1 : wr_run) : 0;
            wr_run_prev <= wr_run;
        end
    end

    a_r2_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        wr_latch_o |-> (sup_run >= PWRUP_CYCLES + GLITCH_LEN + 1));

    a_r5_glitch_len: assert property (@(posedge clk) disable iff (!rst_n)
        wr_latch_o |-> (wr_run_prev >= GLITCH_LEN));

    a_r6_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
        wr_latch_o |-> ($past(we_n_i) && !$past(we_n_i, 2)));

    a_r8_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(supply_ok_i) |-> (!wr_latch_o && !rd_allow_o));

    a_r9_read_levels: assert property (@(posedge clk) disable iff (!rst_n)
        rd_allow_o |-> (!$past(ce_n_i) && !$past(oe_n_i)));

    a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_latch_o |=> !wr_latch_o);

endmodule

bind flash_wr_qualifier flash_wr_qualifier_chk #(
    .PWRUP_CYCLES (PWRUP_CYCLES),
    .GLITCH_LEN   (GLITCH_LEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n_i      (ce_n_i),
    .oe_n_i      (oe_n_i),
    .we_n_i      (we_n_i),
    .supply_ok_i (supply_ok_i),
    .wr_latch_o  (wr_latch_o),
    .rd_allow_o  (rd_allow_o)
);

// File: tb/flash_wr_qualifier_tb.sv
module flash_wr_qualifier_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 20;
    localparam int GL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, sup = 1'b0;
    logic wr_latch, rd_allow;

    int checks = 0;
    int errors = 0;
    int lat_cnt = 0;
    string cur_req = "R1";

    // Behavioural reference state
    int  m_pu = 0;
    int  m_run = 0;
    logic exp_latch = 1'b0;
    logic exp_rd = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_wr_qualifier #(.PWRUP_CYCLES(PW), .GLITCH_LEN(GL)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
        .supply_ok_i(sup), .wr_latch_o(wr_latch), .rd_allow_o(rd_allow)
    );

    // Reference model: outputs follow from the requirements, per edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pu = 0; m_run = 0; exp_latch = 1'b0; exp_rd = 1'b0;
        end else begin
            exp_latch = (m_run >= GL) && we_n && oe_n && sup;
            exp_rd    = sup && !ce_n && !oe_n;
            m_run = (sup && (m_pu >= PW) && !ce_n && !we_n && oe_n) ? m_run + 1 : 0;
            m_pu  = sup ? m_pu + 1 : 0;
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        checks++;
        if (wr_latch !== exp_latch || rd_allow !== exp_rd) begin
            errors++;
            $display("FAIL %s model: latch=%b rd=%b expected latch=%b rd=%b",
                     cur_req, wr_latch, rd_allow, exp_latch, exp_rd);
        end
        if (wr_latch === 1'b1) lat_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // A write holding the write level for n sampled edges.
    task automatic do_write(input int n);
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1;
        repeat (n) @(negedge clk);
        we_n = 1;
        @(negedge clk); ce_n = 1;
        idle(2);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int base;
        idle(3);
        chk("R1 reset latch", wr_latch, 0);
        chk("R1 reset rd", rd_allow, 0);
        rst_n = 1; sup = 1;
        @(negedge clk);
        chk("R1 after release", wr_latch | rd_allow, 0);

        cur_req = "R2"; base = lat_cnt;
        do_write(8);
        chk("R2 write during hold-off", lat_cnt - base, 0);
        idle(PW + 5);

        cur_req = "R5"; base = lat_cnt;
        do_write(1); do_write(2);
        chk("R5 short pulses", lat_cnt - base, 0);

        cur_req = "R6"; base = lat_cnt;
        do_write(GL);
        chk("R6 minimal accepted write", lat_cnt - base, 1);

        cur_req = "R10"; base = lat_cnt;
        do_write(12);
        chk("R10 long write single pulse", lat_cnt - base, 1);

        cur_req = "R4"; base = lat_cnt;
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 0;
        idle(6); we_n = 1; oe_n = 1;
        @(negedge clk); ce_n = 1; idle(2);
        chk("R4 oe low blocks write", lat_cnt - base, 0);

        cur_req = "R7"; base = lat_cnt;
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1;
        idle(5); ce_n = 1;
        @(negedge clk); we_n = 1; idle(2);
        chk("R7 ce rise before we", lat_cnt - base, 0);
        base = lat_cnt;
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1;
        idle(5); we_n = 1; oe_n = 0;
        @(negedge clk); ce_n = 1; oe_n = 1; idle(2);
        chk("R7 oe falls with we rise", lat_cnt - base, 0);

        cur_req = "R9";
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1;
        @(negedge clk);
        chk("R9 read permit", rd_allow, 1);

        cur_req = "R8";
        sup = 0;
        @(negedge clk);
        chk("R8 read blocked low supply", rd_allow, 0);
        idle(2);
        ce_n = 1; oe_n = 1; sup = 1;

        cur_req = "R3"; base = lat_cnt;
        do_write(8);
        chk("R3 hold-off restarted", lat_cnt - base, 0);
        idle(PW + 3);
        base = lat_cnt;
        do_write(4);
        chk("R3 write after re-arm", lat_cnt - base, 1);

        cur_req = "R8"; base = lat_cnt;
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1;
        idle(5); we_n = 1; sup = 0;
        @(negedge clk); ce_n = 1; idle(2);
        chk("R8 supply drop at we rise", lat_cnt - base, 0);
        sup = 1;
        idle(PW + 3);
        base = lat_cnt;
        do_write(5);
        chk("R6 recovered write", lat_cnt - base, 1);

        idle(3);
        finish_run();
    end
endmodule